// File: doc/BRIEF.md
# Conditional-Sum Adder with Optional Level Registers

This block adds two W-bit unsigned operands and a single carry-in. It gives a W-bit sum and a carry-out. It does not let a carry ripple from bit to bit. Instead it works in two steps:

- **First step.** Every bit position works out two results ahead of time. One result assumes that no carry arrives from below. The other assumes that one does.
- **Merge steps.** A tree of log2(W) levels of 2:1 selectors joins neighbouring groups. The group width doubles at each level. The lower group's carry, taken under each assumption, picks which of the upper group's two results is kept.

After the last level, two full-width results remain. The real carry-in picks one of them.

A build parameter decides where registers go. With it set, a register follows the first step and each merge level. A valid flag travels through the same registers as the data, so a new operand pair can enter on every clock. With it cleared, the block is pure logic and the result appears in the same cycle.

Top module: `cond_sum_adder`

## Requirements
- R1: For each bit on its own, the result matches the single-bit rules. With no incoming carry, sum = a XOR b and carry = a AND b. With an incoming carry, sum = NOT(a XOR b) and carry = a OR b. This holds for any operand that has one bit set, in any position.
- R2: The value {carry_out, sum} equals op_a + op_b + carry_in, taken as a (W+1)-bit unsigned number.
- R3: For the same operands, the carry-in-1 result equals the carry-in-0 result plus one, taken as (W+1)-bit values.
- R4: The extreme operands give these results:
  - All-ones plus all-ones with carry_in 1 gives an all-ones sum and carry_out 1.
  - All-ones plus zero with carry_in 1 gives a zero sum and carry_out 1.
  - Zero plus zero with carry_in 1 gives a sum of 1 and carry_out 0.
- R5: With PIPELINE = 1, a pair taken at rising edge n appears on the outputs after edge n + log2(W). This is log2(W)+1 register stages. out_valid is high in exactly that cycle and in no earlier cycle.
- R6: A synchronous active-high rst clears every stage's valid flag. out_valid stays low during reset, and no result that was in flight before reset ever appears.
- R7: With PIPELINE = 0, out_valid equals in_valid and the result appears in the same cycle, with no register in the path.
- R8: With PIPELINE = 1, the block accepts a new pair on every cycle. Any pattern of idle cycles in in_valid comes out unchanged on out_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Marks op_a, op_b and carry_in as meaningful |
| op_a | input | W | First operand |
| op_b | input | W | Second operand |
| carry_in | input | 1 | Carry into the least significant bit |
| out_valid | output | 1 | Marks sum and carry_out as meaningful |
| sum | output | W | Low W bits of the total |
| carry_out | output | 1 | Bit W of the total |

## Verification
The assertions assume that the operands and carry-in are known, non-X values whenever in_valid is high. They also assume these inputs are steady around each rising edge. The bench meets both conditions by driving every input on the falling edge and keeping them driven, to zero or to data, at all times. The assertions also take W to be a power of two that is at least 2, and the bench keeps to W = 16. The reset property assumes reset lasts at least one edge. The bench holds reset for several edges at start-up and again in the middle of the run.

// File: rtl/csa_pkg.sv
`timescale 1ns/1ps
package csa_pkg;

    // Both outcomes of one bit position, one for each carry assumption.
    typedef struct packed {
        logic s_nc;   // sum if no carry arrives
        logic c_nc;   // carry if no carry arrives
        logic s_wc;   // sum if a carry arrives
        logic c_wc;   // carry if a carry arrives
    } bit_cand_t;

    function automatic bit_cand_t dual_half_add(input logic a, input logic b);
        bit_cand_t r;
        r.s_nc = a ^ b;
        r.c_nc = a & b;
        r.s_wc = ~(a ^ b);
        r.c_wc = a | b;
        return r;
    endfunction

    function automatic int unsigned merge_depth(input int unsigned w);
        return $clog2(w);
    endfunction

    function automatic logic pick(input logic sel, input logic if0, input logic if1);
        return sel ? if1 : if0;
    endfunction

endpackage

// File: rtl/csa_bit_stage.sv
`timescale 1ns/1ps
module csa_bit_stage #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] s_nc,
    output logic [W-1:0] c_nc,
    output logic [W-1:0] s_wc,
    output logic [W-1:0] c_wc
);
    import csa_pkg::*;

    for (genvar i = 0; i < W; i++) begin : g_bit
        bit_cand_t cand;
        assign cand    = dual_half_add(a[i], b[i]);
        assign s_nc[i] = cand.s_nc;
        assign c_nc[i] = cand.c_nc;
        assign s_wc[i] = cand.s_wc;
        assign c_wc[i] = cand.c_wc;
    end
endmodule

// File: rtl/csa_merge_level.sv
`timescale 1ns/1ps
module csa_merge_level #(
    parameter int W   = 16,
    parameter int GIN = 1
) (
    input  logic [W-1:0] s_nc_i,
    input  logic [W-1:0] c_nc_i,
    input  logic [W-1:0] s_wc_i,
    input  logic [W-1:0] c_wc_i,
    output logic [W-1:0] s_nc_o,
    output logic [W-1:0] c_nc_o,
    output logic [W-1:0] s_wc_o,
    output logic [W-1:0] c_wc_o
);
    localparam int GOUT = 2 * GIN;
    localparam int NGRP = W / GOUT;

    for (genvar g = 0; g < NGRP; g++) begin : g_pair
        localparam int LO  = g * GOUT;
        localparam int UP  = LO + GIN;
        localparam int TOP = LO + GIN - 1;   // carry position of the lower group

        // lower group passes through unchanged
        assign s_nc_o[LO +: GIN] = s_nc_i[LO +: GIN];
        assign c_nc_o[LO +: GIN] = c_nc_i[LO +: GIN];
        assign s_wc_o[LO +: GIN] = s_wc_i[LO +: GIN];
        assign c_wc_o[LO +: GIN] = c_wc_i[LO +: GIN];

        // upper group: lower carry under each assumption picks its outcome
        assign s_nc_o[UP +: GIN] = c_nc_i[TOP] ? s_wc_i[UP +: GIN] : s_nc_i[UP +: GIN];
        assign c_nc_o[UP +: GIN] = c_nc_i[TOP] ? c_wc_i[UP +: GIN] : c_nc_i[UP +: GIN];
        assign s_wc_o[UP +: GIN] = c_wc_i[TOP] ? s_wc_i[UP +: GIN] : s_nc_i[UP +: GIN];
        assign c_wc_o[UP +: GIN] = c_wc_i[TOP] ? c_wc_i[UP +: GIN] : c_nc_i[UP +: GIN];
    end
endmodule

// File: rtl/csa_stage_reg.sv
`timescale 1ns/1ps
module csa_stage_reg #(
    parameter int DW = 8,
    parameter bit EN = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          vld_i,
    input  logic [DW-1:0] d_i,
    output logic          vld_o,
    output logic [DW-1:0] d_o
);
    if (EN) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                vld_o <= 1'b0;
                d_o   <= '0;
            end else begin
                vld_o <= vld_i;
                d_o   <= d_i;
            end
        end

        // R5 / R8: each stage hands the valid flag on one edge later
        p_valid_follow_r5: assert property (@(posedge clk) disable iff (rst)
            $past(!rst) |-> (vld_o == $past(vld_i)));

        // R6: a cycle in reset leaves the stage empty
        p_reset_clear_r6: assert property (@(posedge clk)
            $past(rst) |-> !vld_o);
    end else begin : g_wire
        assign vld_o = vld_i;
        assign d_o   = d_i;
    end
endmodule

// File: rtl/cond_sum_adder.sv
`timescale 1ns/1ps
module cond_sum_adder #(
    parameter int W        = 16,
    parameter bit PIPELINE = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic         carry_in,
    output logic         out_valid,
    output logic [W-1:0] sum,
    output logic         carry_out
);
    import csa_pkg::*;

    localparam int LEVELS = merge_depth(W);
    localparam int DW     = 4 * W + 1;

    typedef struct packed {
        logic         cin;
        logic [W-1:0] s_nc;
        logic [W-1:0] c_nc;
        logic [W-1:0] s_wc;
        logic [W-1:0] c_wc;
    } stage_t;

    stage_t pre_q  [LEVELS+1];   // logic result feeding stage register k
    stage_t post_q [LEVELS+1];   // output of stage register k
    logic   vld    [LEVELS+2];

    assign vld[0] = in_valid;

    // first step: both outcomes for every bit
    csa_bit_stage #(.W(W)) u_bits (
        .a    (op_a),
        .b    (op_b),
        .s_nc (pre_q[0].s_nc),
        .c_nc (pre_q[0].c_nc),
        .s_wc (pre_q[0].s_wc),
        .c_wc (pre_q[0].c_wc)
    );
    assign pre_q[0].cin = carry_in;

    for (genvar k = 0; k <= LEVELS; k++) begin : g_stage
        logic [DW-1:0] d_flat;
        logic [DW-1:0] q_flat;
        assign d_flat    = pre_q[k];
        assign post_q[k] = stage_t'(q_flat);

        csa_stage_reg #(.DW(DW), .EN(PIPELINE)) u_reg (
            .clk   (clk),
            .rst   (rst),
            .vld_i (vld[k]),
            .d_i   (d_flat),
            .vld_o (vld[k+1]),
            .d_o   (q_flat)
        );

        if (k < LEVELS) begin : g_merge
            csa_merge_level #(.W(W), .GIN(1 << k)) u_merge (
                .s_nc_i (post_q[k].s_nc),
                .c_nc_i (post_q[k].c_nc),
                .s_wc_i (post_q[k].s_wc),
                .c_wc_i (post_q[k].c_wc),
                .s_nc_o (pre_q[k+1].s_nc),
                .c_nc_o (pre_q[k+1].c_nc),
                .s_wc_o (pre_q[k+1].s_wc),
                .c_wc_o (pre_q[k+1].c_wc)
            );
            assign pre_q[k+1].cin = post_q[k].cin;
        end
    end

    // final choice by the real carry-in
    stage_t fin;
    assign fin       = post_q[LEVELS];
    assign out_valid = vld[LEVELS+1];
    assign sum       = fin.cin ? fin.s_wc : fin.s_nc;
    assign carry_out = pick(fin.cin, fin.c_nc[W-1], fin.c_wc[W-1]);

    // R3: the two full-width outcomes are one apart
    p_cand_step_r3: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ({fin.c_wc[W-1], fin.s_wc} == ({fin.c_nc[W-1], fin.s_nc} + (W+1)'(1))));

    // R1: a carry without an incoming carry implies one with it
    p_carry_order_r1: assert property (@(posedge clk) disable iff (rst)
        vld[1] |-> ((post_q[0].c_nc & ~post_q[0].c_wc) == '0));

    if (!PIPELINE) begin : g_comb_chk
        // R2 / R7: same-cycle total when no registers are present
        p_comb_sum_r2: assert property (@(posedge clk) disable iff (rst)
            in_valid |-> ({carry_out, sum} == ({1'b0, op_a} + {1'b0, op_b} + (W+1)'(carry_in))));
        p_comb_valid_r7: assert property (@(posedge clk) disable iff (rst)
            out_valid == in_valid);
    end
endmodule

// File: tb/test_cond_sum_adder.sv
`timescale 1ns/1ps
module test_cond_sum_adder;
    localparam int W      = 16;
    localparam int LEVELS = $clog2(W);
    localparam int LAT    = LEVELS + 1;
    localparam int RING   = 64;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic         in_valid = 1'b0;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic         carry_in = 1'b0;

    logic         p_valid, c_valid, p_cout, c_cout;
    logic [W-1:0] p_sum, c_sum;

    cond_sum_adder #(.W(W), .PIPELINE(1'b1)) i_cond_sum_adder (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .carry_in(carry_in), .out_valid(p_valid), .sum(p_sum), .carry_out(p_cout));

    cond_sum_adder #(.W(W), .PIPELINE(1'b0)) i_cond_sum_adder_comb (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .carry_in(carry_in), .out_valid(c_valid), .sum(c_sum), .carry_out(c_cout));

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;
    logic         hv [RING];
    logic [W:0]   hx [RING];
    string        ht [RING];

    task automatic check(input string req, input logic [W:0] act, input logic [W:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic clear_hist();
        for (int i = 0; i < RING; i++) hv[i] = 1'b0;
    endtask

    // one falling edge: check registered result, drive new pair, check logic-only result
    task automatic step(input logic v, input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic ci, input string tag);
        int old;
        logic [W:0] exp;
        @(negedge clk);
        old = (cyc + RING - LAT) % RING;
        check("R5 out_valid timing", (W+1)'(p_valid), (W+1)'(hv[old]));
        if (hv[old]) check({ht[old], " piped"}, {p_cout, p_sum}, hx[old]);
        in_valid = v; op_a = a; op_b = b; carry_in = ci;
        exp = {1'b0, a} + {1'b0, b} + (W+1)'(ci);
        hv[cyc % RING] = v; hx[cyc % RING] = exp; ht[cyc % RING] = tag;
        #1;
        check("R7 comb valid", (W+1)'(c_valid), (W+1)'(v));
        if (v) check({tag, " comb"}, {c_cout, c_sum}, exp);
        cyc++;
    endtask

    task automatic do_reset(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (k > 0) check("R6 valid low in reset", (W+1)'(p_valid), '0);
            rst = 1'b1; in_valid = 1'b0;
            cyc++;
        end
        @(negedge clk);
        check("R6 valid low in reset", (W+1)'(p_valid), '0);
        clear_hist();
        rst = 1'b0;
        cyc++;
    endtask

    task automatic t_single_bit();   // R1
        for (int i = 0; i < W; i++)
            for (int ab = 0; ab < 4; ab++)
                for (int ci = 0; ci < 2; ci++)
                    step(1'b1, W'(ab >> 1) << i, W'(ab & 1) << i, ci[0], "R1");
    endtask

    task automatic t_corners();      // R4 and R3
        logic [W:0] r0;
        step(1'b1, '1, '1, 1'b1, "R4");
        check("R4 all ones", {c_cout, c_sum}, {1'b1, {W{1'b1}}});
        step(1'b1, '1, '0, 1'b1, "R4");
        check("R4 wrap to zero", {c_cout, c_sum}, {1'b1, {W{1'b0}}});
        step(1'b1, '0, '0, 1'b1, "R4");
        check("R4 zero plus carry", {c_cout, c_sum}, (W+1)'(1));
        for (int j = 0; j < 8; j++) begin
            logic [W-1:0] a = W'($urandom);
            logic [W-1:0] b = (j == 0) ? ~a : W'($urandom);
            step(1'b1, a, b, 1'b0, "R3");
            r0 = {c_cout, c_sum};
            step(1'b1, a, b, 1'b1, "R3");
            check("R3 carry-in step", {c_cout, c_sum}, r0 + (W+1)'(1));
        end
    endtask

    task automatic t_latency();      // R5
        for (int k = 0; k < LAT + 1; k++) step(1'b0, '0, '0, 1'b0, "R5");
        step(1'b1, 16'h8001, 16'h7fff, 1'b1, "R5");
        for (int k = 0; k < LAT + 2; k++) step(1'b0, '0, '0, 1'b0, "R5");
    endtask

    task automatic t_gaps();         // R8
        for (int k = 0; k < 300; k++)
            step((k % 3) != 0, W'($urandom), W'($urandom), 1'($urandom), "R8");
    endtask

    task automatic t_random();       // R2
        for (int k = 0; k < 1500; k++)
            step(1'b1, W'($urandom), W'($urandom), 1'($urandom), "R2");
    endtask

    task automatic t_midreset();     // R6
        for (int k = 0; k < 3; k++) step(1'b1, W'($urandom), W'($urandom), 1'b1, "R6");
        do_reset(2);
        for (int k = 0; k < LAT + 1; k++) step(1'b0, '0, '0, 1'b0, "R6");
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        clear_hist();
        do_reset(4);
        t_single_bit();
        t_corners();
        t_latency();
        t_gaps();
        t_random();
        t_midreset();
        for (int k = 0; k < LAT + 1; k++) step(1'b0, '0, '0, 1'b0, "R5");
        summary();
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog: run did not end, actual hung expected done");
        summary();
        $finish;
    end
endmodule